// File: doc/BRIEF.md
# Triangular Spread-Spectrum Divide Modulator

This block feeds a fractional-N feedback divider. It adds a triangular offset to a nominal fixed-point divide value, once per reference cycle. The swept divide value lowers the peak energy of the synthesized clock. Two spread shapes are available. In down spread the divide value never rises above the nominal value. In center spread the divide value moves evenly above and below the nominal value, so the mean phase matches the unmodulated clock. A first-order fractional accumulator turns the modulated fixed-point word into the integer divide ratio that the divider uses on each cycle.

Software supplies four settings: the shape, a 3-bit amount code, a rate code and the nominal word. The rate code sets the half-period of the triangle as a power of two of reference cycles. The system picks that power of two from the VCO or reference frequency so that the sweep lands in the 30 kHz to 60 kHz band. A new shape, amount, rate or nominal word on the modulated path is sampled only when a triangle period starts. A bypass input forces the modulated outputs to zero. While bypass is high, the unmodulated word is still delivered.

Top module: `ssc_mod_gen`

## Requirements
- R1: While `rst_ni` is low, `nom_div_o`, `ssc_div_o` and `ssc_int_o` are all zero.
- R2: `nom_div_o` equals the `nom_i` of the previous clock. This holds whether or not bypass is high.
- R3: While `bypass_i` is high, `ssc_div_o` and `ssc_int_o` read zero from the next clock on.
- R4: The amount code selects the peak-to-peak span in units of 2^-11 of the nominal word. The codes 0 to 7 select 4, 10, 16, 20, 31, 41, 61 and 0 units. The per-cycle step is `((nom*units) >> 11) >> h`, where h is the rate code and a rate code of 0 is treated as 1.
- R5: The triangle moves by exactly one step on every clock. It rises for 2^h clocks and then falls for 2^h clocks, so a full period is 2^(h+1) clocks. Consecutive `ssc_div_o` samples therefore always differ by exactly the step.
- R6: In down spread (`mode_i`=1), the maximum of `ssc_div_o` equals the nominal word and the minimum equals the nominal word minus step*2^h.
- R7: In center spread (`mode_i`=0), `ssc_div_o` ranges from nominal minus step*2^(h-1) to nominal plus step*2^(h-1). Its sum over one full period equals 2^(h+1) times the nominal word.
- R8: On the modulated path, changes to shape, amount, rate or nominal word take effect only at the next period start. A period starts at the sample where the triangle sits at its zero-offset end: the top in down spread, the bottom in center spread.
- R9: `ssc_int_o` carries the integer part of the previous `ssc_div_o`, plus the carry of a FRAC_W-bit accumulator of its fractional part. For a constant word of integer part I and fraction f/2^FRAC_W, any 2^FRAC_W/gcd consecutive outputs are I or I+1, and their mean is exact. For example, f=64 with FRAC_W=8 gives a 4-output sum of 4I+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bypass_i | input | 1 | Forces the modulated outputs to zero |
| mode_i | input | 1 | Spread shape: 0 center, 1 down |
| amt_i | input | 3 | Amount code (R4) |
| rate_i | input | RATE_W | Log2 of the half-period in clocks |
| nom_i | input | DIV_W+FRAC_W | Nominal divide word, unsigned fixed point with FRAC_W fraction bits |
| nom_div_o | output | DIV_W+FRAC_W | Unmodulated divide word |
| ssc_div_o | output | DIV_W+FRAC_W | Modulated divide word |
| ssc_int_o | output | DIV_W | Integer divide ratio after fractional accumulation |

## Verification
A corrupted step or position register shows up at once, because every `ssc_div_o` sample would no longer differ from its neighbour by exactly one step. A wrong peak or wrong turn-around point breaks the top or bottom value within one period of 2^(h+1) clocks. A configuration latch that updates too early shows up inside the period in which the change is made, because the old step stops appearing before the zero-offset end is reached. A faulty fractional carry upsets the sum of the integer outputs within one accumulator cycle of a few clocks.

// File: rtl/ssc_mod_pkg.sv
package ssc_mod_pkg;
  localparam int UNIT_W   = 6;
  localparam int SCALE_SH = 11;

  typedef enum logic {
    SPREAD_CENTER = 1'b0,
    SPREAD_DOWN   = 1'b1
  } spread_mode_e;

  // peak-to-peak span in 2^-11 of nominal
  function automatic logic [UNIT_W-1:0] amt_units(input logic [2:0] code);
    logic [UNIT_W-1:0] u;
    case (code)
      3'd0:    u = UNIT_W'(4);
      3'd1:    u = UNIT_W'(10);
      3'd2:    u = UNIT_W'(16);
      3'd3:    u = UNIT_W'(20);
      3'd4:    u = UNIT_W'(31);
      3'd5:    u = UNIT_W'(41);
      3'd6:    u = UNIT_W'(61);
      default: u = '0;
    endcase
    return u;
  endfunction
endpackage

// File: rtl/ssc_span_calc.sv
module ssc_span_calc
  import ssc_mod_pkg::*;
#(
  parameter int NOM_W  = 16,
  parameter int RATE_W = 4,
  parameter int SPAN_W = NOM_W + UNIT_W - SCALE_SH
) (
  input  logic [NOM_W-1:0]  nom_i,
  input  logic [2:0]        amt_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [SPAN_W-1:0] step_o,
  output logic [RATE_W-1:0] hlog_o
);
  localparam int PROD_W = NOM_W + UNIT_W;

  logic [PROD_W-1:0] prod;
  logic [SPAN_W-1:0] span;

  always_comb begin
    prod   = PROD_W'(nom_i) * PROD_W'(amt_units(amt_i));
    span   = prod[PROD_W-1:SCALE_SH];
    hlog_o = (rate_i == '0) ? RATE_W'(1) : rate_i;
    step_o = span >> hlog_o;
  end
endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
  import ssc_mod_pkg::*;
#(
  parameter int NOM_W  = 16,
  parameter int RATE_W = 4,
  parameter int SPAN_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SPAN_W-1:0] step_i,
  input  logic [RATE_W-1:0] hlog_i,
  input  spread_mode_e      mode_i,
  input  logic [NOM_W-1:0]  nom_i,
  output logic [SPAN_W-1:0] pos_o,
  output logic [SPAN_W-1:0] step_o,
  output logic [RATE_W-1:0] hlog_o,
  output spread_mode_e      mode_o,
  output logic [NOM_W-1:0]  nom_o,
  output logic              dir_o,
  output logic              load_o
);
  localparam int CNT_W = 1 << RATE_W;

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] hmax;

  assign hmax   = (CNT_W'(1) << hlog_o) - CNT_W'(1);
  // period boundary: last falling step, or first cycle out of reset
  assign load_o = !run_q || (dir_o && cnt_q == hmax);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pos_o  <= '0;
      dir_o  <= 1'b0;
      step_o <= '0;
      hlog_o <= RATE_W'(1);
      mode_o <= SPREAD_CENTER;
      nom_o  <= '0;
    end else if (load_o) begin
      run_q  <= 1'b1;
      cnt_q  <= '0;
      pos_o  <= '0;
      dir_o  <= 1'b0;
      step_o <= step_i;
      hlog_o <= hlog_i;
      mode_o <= mode_i;
      nom_o  <= nom_i;
    end else if (!dir_o) begin
      pos_o <= pos_o + step_o;
      if (cnt_q == hmax) begin
        cnt_q <= '0;
        dir_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end else begin
      pos_o <= pos_o - step_o;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ssc_frac_acc.sv
module ssc_frac_acc #(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bypass_i,
  input  logic [DIV_W+FRAC_W-1:0] word_i,
  output logic [DIV_W-1:0]        int_o
);
  localparam int NOM_W = DIV_W + FRAC_W;

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, word_i[FRAC_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      int_o <= '0;
    end else if (bypass_i) begin
      acc_q <= '0;
      int_o <= '0;
    end else begin
      acc_q <= sum[FRAC_W-1:0];
      int_o <= word_i[NOM_W-1:FRAC_W] + DIV_W'(sum[FRAC_W]);
    end
  end
endmodule

// File: rtl/ssc_mod_gen.sv
module ssc_mod_gen
  import ssc_mod_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int FRAC_W = 8,
  parameter int RATE_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    bypass_i,
  input  logic                    mode_i,
  input  logic [2:0]              amt_i,
  input  logic [RATE_W-1:0]       rate_i,
  input  logic [DIV_W+FRAC_W-1:0] nom_i,
  output logic [DIV_W+FRAC_W-1:0] nom_div_o,
  output logic [DIV_W+FRAC_W-1:0] ssc_div_o,
  output logic [DIV_W-1:0]        ssc_int_o
);
  localparam int NOM_W  = DIV_W + FRAC_W;
  localparam int SPAN_W = NOM_W + UNIT_W - SCALE_SH;
  localparam int OFF_W  = NOM_W + 2;

  logic [SPAN_W-1:0] step_w;
  logic [RATE_W-1:0] hlog_w;
  logic [SPAN_W-1:0] tri_pos, tri_step;
  logic [RATE_W-1:0] tri_hlog;
  spread_mode_e      tri_mode;
  logic [NOM_W-1:0]  tri_nom;
  logic              tri_dir, tri_load;

  logic [SPAN_W-1:0]       half_u;
  logic signed [OFF_W-1:0] pos_s, half_s, off_s;
  logic [NOM_W-1:0]        ssc_next;

  ssc_span_calc #(.NOM_W(NOM_W), .RATE_W(RATE_W), .SPAN_W(SPAN_W)) i_span (
    .nom_i  (nom_i),
    .amt_i  (amt_i),
    .rate_i (rate_i),
    .step_o (step_w),
    .hlog_o (hlog_w)
  );

  ssc_tri_gen #(.NOM_W(NOM_W), .RATE_W(RATE_W), .SPAN_W(SPAN_W)) i_tri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_w),
    .hlog_i (hlog_w),
    .mode_i (spread_mode_e'(mode_i)),
    .nom_i  (nom_i),
    .pos_o  (tri_pos),
    .step_o (tri_step),
    .hlog_o (tri_hlog),
    .mode_o (tri_mode),
    .nom_o  (tri_nom),
    .dir_o  (tri_dir),
    .load_o (tri_load)
  );

  // down: 0 .. -peak ; center: -peak/2 .. +peak/2
  always_comb begin
    half_u   = tri_step << (tri_hlog - RATE_W'(1));
    pos_s    = signed'({{(OFF_W-SPAN_W){1'b0}}, tri_pos});
    half_s   = signed'({{(OFF_W-SPAN_W){1'b0}}, half_u});
    off_s    = (tri_mode == SPREAD_DOWN) ? -pos_s : (pos_s - half_s);
    ssc_next = NOM_W'(signed'({2'b00, tri_nom}) + off_s);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nom_div_o <= '0;
      ssc_div_o <= '0;
    end else begin
      nom_div_o <= nom_i;
      ssc_div_o <= bypass_i ? '0 : ssc_next;
    end
  end

  ssc_frac_acc #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) i_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (bypass_i),
    .word_i   (ssc_div_o),
    .int_o    (ssc_int_o)
  );
endmodule

// File: rtl/ssc_mod_gen_chk.sv
module ssc_mod_gen_chk
  import ssc_mod_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int NOM_W  = 16,
  parameter int RATE_W = 4,
  parameter int SPAN_W = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bypass_i,
  input logic [NOM_W-1:0]  nom_i,
  input logic [NOM_W-1:0]  nom_div_o,
  input logic [NOM_W-1:0]  ssc_div_o,
  input logic [DIV_W-1:0]  ssc_int_o,
  input logic [SPAN_W-1:0] tri_pos,
  input logic [SPAN_W-1:0] tri_step,
  input logic [RATE_W-1:0] tri_hlog,
  input spread_mode_e      tri_mode,
  input logic [NOM_W-1:0]  tri_nom,
  input logic              tri_dir,
  input logic              tri_load
);
  localparam int PK_W = 2 * SPAN_W + (1 << RATE_W);

  logic [PK_W-1:0] peak_w;
  assign peak_w = PK_W'(tri_step) << tri_hlog;

  // R2
  nom_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> nom_div_o == $past(nom_i));

  // R3
  bypass_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (ssc_div_o == '0) && (ssc_int_o == '0));

  // R5
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    PK_W'(tri_pos) <= peak_w);

  // R5
  fall_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tri_dir && !tri_load |=> tri_pos <= $past(tri_pos));

  // R6
  down_ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_mode == SPREAD_DOWN) && !bypass_i |=> ssc_div_o <= $past(tri_nom));

  // R8
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tri_load |=> $stable(tri_step) && $stable(tri_hlog) && $stable(tri_mode) && $stable(tri_nom));
endmodule

bind ssc_mod_gen ssc_mod_gen_chk #(
  .DIV_W(DIV_W), .NOM_W(DIV_W + FRAC_W), .RATE_W(RATE_W),
  .SPAN_W(DIV_W + FRAC_W + ssc_mod_pkg::UNIT_W - ssc_mod_pkg::SCALE_SH)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bypass_i  (bypass_i),
  .nom_i     (nom_i),
  .nom_div_o (nom_div_o),
  .ssc_div_o (ssc_div_o),
  .ssc_int_o (ssc_int_o),
  .tri_pos   (tri_pos),
  .tri_step  (tri_step),
  .tri_hlog  (tri_hlog),
  .tri_mode  (tri_mode),
  .tri_nom   (tri_nom),
  .tri_dir   (tri_dir),
  .tri_load  (tri_load)
);

// File: tb/test_ssc_mod_gen.sv
module test_ssc_mod_gen;
  localparam int DIV_W = 8, FRAC_W = 8, RATE_W = 4, NOM_W = 16;
  localparam int NOM = 25600;  // 100.0

  logic clk_i = 1'b0, rst_ni = 1'b0, bypass_i = 1'b0, mode_i = 1'b1;
  logic [2:0]        amt_i  = 3'd3;
  logic [RATE_W-1:0] rate_i = 4'd3;
  logic [NOM_W-1:0]  nom_i  = 16'(NOM);
  logic [NOM_W-1:0]  nom_div_o, ssc_div_o;
  logic [DIV_W-1:0]  ssc_int_o;

  int total = 0, bad = 0;
  int smp [0:63];

  always #5 clk_i = ~clk_i;

  ssc_mod_gen #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .RATE_W(RATE_W)) i_ssc_mod_gen (
    .clk_i, .rst_ni, .bypass_i, .mode_i, .amt_i, .rate_i, .nom_i,
    .nom_div_o, .ssc_div_o, .ssc_int_o
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic grab(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      smp[i] = int'(ssc_div_o);
    end
  endtask

  task automatic set_cfg(input logic m, input logic [2:0] a, input logic [RATE_W-1:0] r, input int n);
    @(negedge clk_i);
    mode_i = m; amt_i = a; rate_i = r; nom_i = 16'(n);
    repeat (80) @(negedge clk_i);
  endtask

  // checks range, step size on every neighbour pair, and optional period sum
  task automatic tri_check(input string req, input int n, input int step,
                           input int lo, input int hi, input int per);
    int mx = smp[0], mn = smp[0], badstep = 0, sum = 0;
    grab(n);
    mx = smp[0]; mn = smp[0];
    for (int i = 1; i < n; i++) begin
      if (smp[i] > mx) mx = smp[i];
      if (smp[i] < mn) mn = smp[i];
      if ((smp[i] - smp[i-1] != step) && (smp[i-1] - smp[i] != step)) badstep++;
    end
    chk({req, " max"}, mx, hi);
    chk({req, " min"}, mn, lo);
    chk({req, " R5 step mismatches"}, badstep, 0);
    if (per > 0) begin
      for (int i = 0; i < per; i++) sum += smp[i];
      chk({req, " R7 period sum"}, sum, per * NOM);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    chk("R1 nom_div_o", int'(nom_div_o), 0);
    chk("R1 ssc_div_o", int'(ssc_div_o), 0);
    chk("R1 ssc_int_o", int'(ssc_int_o), 0);
    rst_ni = 1'b1;
  endtask

  task automatic t_nom_track;
    @(negedge clk_i); nom_i = 16'(12345);
    @(negedge clk_i); chk("R2 nom follow", int'(nom_div_o), 12345);
    nom_i = 16'(NOM);
    @(negedge clk_i); chk("R2 nom follow back", int'(nom_div_o), NOM);
  endtask

  task automatic t_bypass;
    @(negedge clk_i); bypass_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R3 ssc_div_o zero", int'(ssc_div_o), 0);
    chk("R3 ssc_int_o zero", int'(ssc_int_o), 0);
    nom_i = 16'(20000);
    @(negedge clk_i);
    chk("R2 nom during bypass", int'(nom_div_o), 20000);
    chk("R3 still zero", int'(ssc_div_o), 0);
    nom_i = 16'(NOM); bypass_i = 1'b0;
    repeat (40) @(negedge clk_i);
    chk("R3 recovers (nonzero)", int'(ssc_div_o != 0), 1);
  endtask

  task automatic t_down;
    // R4 code3: 20 units -> span 250, h=3 step 31, peak 248
    set_cfg(1'b1, 3'd3, 4'd3, NOM);
    tri_check("R6 down c3", 32, 31, NOM - 248, NOM, 0);
    // R4 code4: 31 units -> span 387, rate 0 => h=1, step 193
    set_cfg(1'b1, 3'd4, 4'd0, NOM);
    tri_check("R4 R6 down c4 rate0", 8, 193, NOM - 386, NOM, 0);
  endtask

  task automatic t_center;
    // code1: 10 units -> span 125, h=2 step 31, half 62
    set_cfg(1'b0, 3'd1, 4'd2, NOM);
    tri_check("R7 center c1", 16, 31, NOM - 62, NOM + 62, 8);
    // code2: 16 units -> span 200, h=4 step 12, half 96
    set_cfg(1'b0, 3'd2, 4'd4, NOM);
    tri_check("R4 R7 center c2", 40, 12, NOM - 96, NOM + 96, 32);
  endtask

  task automatic t_change;
    int cnt = 0, badstep = 0, prev = NOM;
    set_cfg(1'b1, 3'd3, 4'd3, NOM);
    while (int'(ssc_div_o) != NOM && cnt < 40) begin
      @(negedge clk_i); cnt++;
    end
    amt_i = 3'd6;  // 61 units -> span 762, step 95
    grab(17);
    for (int i = 0; i < 15; i++) begin
      if ((prev - smp[i] != 31) && (smp[i] - prev != 31)) badstep++;
      prev = smp[i];
    end
    chk("R8 old step kept in period", badstep, 0);
    chk("R8 boundary at top", smp[15], NOM);
    chk("R8 new step after boundary", smp[16], NOM - 95);
  endtask

  task automatic t_frac;
    int s = 0, outside = 0;
    set_cfg(1'b1, 3'd7, 4'd2, NOM + 64);  // code7 zero span, 100.25
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      s += int'(ssc_int_o);
      if (ssc_int_o != 8'd100 && ssc_int_o != 8'd101) outside++;
    end
    chk("R4 code7 no spread", int'(ssc_div_o), NOM + 64);
    chk("R9 int sum over 4", s, 401);
    chk("R9 int values", outside, 0);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog R1-R9 actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_nom_track();
    t_bypass();
    t_down();
    t_center();
    t_change();
    t_frac();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule